// File: doc/BRIEF.md
# Multi-Lane SPI Shift Engine

This block is the data path of an SPI controller with several parallel data lanes (two by default). All lanes share one serial clock and one active-low chip select. Each transfer is started with a 2-bit lane mode and a length in words. Transmit words are taken from a valid/ready stream, and receive words are returned as one-cycle valid pulses.

The modes spread the words across the lanes in three ways. Single mode behaves like an ordinary one-lane SPI link on lane 0. Mirror mode shifts one word out on every lane at once and returns nothing. Stripe mode gives each lane its own word in every word period, so a transfer moves one word per lane per period. In stripe mode the engine collects one transmit word per lane before each word period. After the period it returns the received words in lane order.

The serial timing is SPI mode 0. The clock idles low, outgoing bits change only while the clock is low, and incoming bits are sampled on the rising edge. Bits are shifted most significant bit first. A request with an illegal mode or length is rejected without touching the serial pins.

Top module: `mlspi_shift`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, every `sdo` lane is 0, and `busy`, `tx_ready`, `rx_valid`, `done` and `err` are all 0.
- R2: The `mode` encodings are 0 = single, 1 = stripe and 2 = mirror. A start with mode 3 is rejected. A rejected start pulses `err` for exactly one cycle, leaves `busy` low and never lowers `cs_n`.
- R3: In single mode each word is shifted MSB first on `sdo[0]`. One receive word is returned per word, sampled from `sdi[0]` MSB first.
- R4: While `cs_n` is low in single mode, every lane above 0 holds `sdo` at 0, and its `sdi` is ignored.
- R5: In mirror mode each transmit word appears on every lane in the same serial clock cycles.
- R6: Mirror mode returns no receive words.
- R7: In stripe mode, buffer word k is shifted out on lane k mod N, where N is the lane count.
- R8: In stripe mode the words received in one period are returned in lane order, lane 0 first. For example, lane 0 returning 0x11 and lane 1 returning 0x88 yields 0x11 followed by 0x88.
- R9: A stripe-mode length that is not a multiple of the lane count is rejected with an `err` pulse before `cs_n` can fall. A length of zero is rejected the same way in any mode.
- R10: `sdo` changes only while `sclk` is low, and `sdi` is sampled on the rising edge of `sclk`.
- R11: `cs_n` falls exactly HALF clock cycles before the first rising `sclk` edge. `cs_n` rises no sooner than HALF clock cycles after the last falling `sclk` edge.
- R12: `busy` is high from the cycle after an accepted start until `cs_n` returns high. `done` is a one-cycle pulse in the cycle in which `cs_n` returns high and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transfer request, sampled while idle |
| mode | input | 2 | Lane mode: 0 single, 1 stripe, 2 mirror |
| len_words | input | LEN_W | Transfer length in words |
| tx_data | input | WORD_W | Transmit word |
| tx_valid | input | 1 | Transmit word present |
| tx_ready | output | 1 | Engine accepts a transmit word |
| rx_data | output | WORD_W | Received word |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | One-cycle pulse on a rejected request |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Chip select, active low |
| sdo | output | LANES | Serial data out, one bit per lane |
| sdi | input | LANES | Serial data in, one bit per lane |

## Verification
The assertions assume that `start` is raised only while `busy` is low. They also assume that the transmit stream can supply every word the transfer length calls for, and that `sdi` changes only while `sclk` is low. The bench honours these assumptions. It loads the transmit queue with exactly the words each transfer needs and waits for `done` or `err` before it issues the next request. Its peripheral model updates `sdi` only on falling `sclk` edges and from the chip-select fall.

// File: rtl/mlspi_shift.sv
module mlspi_shift #(
  parameter int LANES  = 2,
  parameter int WORD_W = 8,
  parameter int LEN_W  = 8,
  parameter int HALF   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [LEN_W-1:0]  len_words,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              sclk,
  output logic              cs_n,
  output logic [LANES-1:0]  sdo,
  input  logic [LANES-1:0]  sdi
);
  localparam int IW    = $clog2(LANES + 1);
  localparam int DEPTH = 1 << IW;
  localparam int BW    = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int CW    = $clog2(HALF + 1);
  localparam logic [1:0] M_SINGLE = 2'd0;
  localparam logic [1:0] M_STRIPE = 2'd1;
  localparam logic [1:0] M_MIRROR = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LO, S_HI, S_PUSH, S_TAIL} st_t;

  st_t               st;
  logic [1:0]        mode_q;
  logic [LEN_W-1:0]  rem;
  logic [IW-1:0]     fidx, pidx, need, npush;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bcnt;
  logic [WORD_W-1:0] stash [DEPTH];
  logic [WORD_W-1:0] rx_sh [DEPTH];
  logic [WORD_W-1:0] tx_sh [LANES];
  logic              bad_req;

  assign need     = (mode_q == M_STRIPE) ? IW'(LANES) : IW'(1);
  assign npush    = (mode_q == M_STRIPE) ? IW'(LANES) :
                    (mode_q == M_SINGLE) ? IW'(1) : IW'(0);
  assign bad_req  = (mode == 2'd3) || (len_words == '0) ||
                    ((mode == M_STRIPE) && ((32'(len_words) % LANES) != 0));
  assign tx_ready = (st == S_FETCH) && (fidx < need);
  assign busy     = (st != S_IDLE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sdo[g] = tx_sh[g][WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mode_q   <= M_SINGLE;
      rem      <= '0;
      fidx     <= '0;
      pidx     <= '0;
      cnt      <= '0;
      bcnt     <= '0;
      sclk     <= 1'b0;
      cs_n     <= 1'b1;
      done     <= 1'b0;
      err      <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        stash[i] <= '0;
        rx_sh[i] <= '0;
      end
      for (int i = 0; i < LANES; i++) tx_sh[i] <= '0;
    end else begin
      done     <= 1'b0;
      err      <= 1'b0;
      rx_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (bad_req) err <= 1'b1;
          else begin
            mode_q <= mode;
            rem    <= len_words;
            fidx   <= '0;
            st     <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (fidx < need) begin
            if (tx_valid) begin
              stash[fidx] <= tx_data;
              fidx        <= fidx + 1'b1;
            end
          end else begin
            for (int i = 0; i < LANES; i++) begin
              case (mode_q)
                M_STRIPE: tx_sh[i] <= stash[i];
                M_MIRROR: tx_sh[i] <= stash[0];
                default:  tx_sh[i] <= (i == 0) ? stash[0] : '0;
              endcase
            end
            cs_n <= 1'b0;
            cnt  <= '0;
            bcnt <= '0;
            st   <= S_LO;
          end
        end
        S_LO: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            sclk <= 1'b1;
            for (int i = 0; i < LANES; i++)
              rx_sh[i] <= {rx_sh[i][WORD_W-2:0], sdi[i]};
            st <= S_HI;
          end
        end
        S_HI: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            sclk <= 1'b0;
            if (bcnt == BW'(WORD_W - 1)) begin
              rem  <= rem - LEN_W'(need);
              pidx <= '0;
              st   <= S_PUSH;
            end else begin
              bcnt <= bcnt + 1'b1;
              for (int i = 0; i < LANES; i++)
                tx_sh[i] <= {tx_sh[i][WORD_W-2:0], 1'b0};
              st <= S_LO;
            end
          end
        end
        S_PUSH: begin
          if (pidx < npush) begin
            rx_valid <= 1'b1;
            rx_data  <= rx_sh[pidx];
            pidx     <= pidx + 1'b1;
          end else if (rem == '0) begin
            cnt <= '0;
            st  <= S_TAIL;
          end else begin
            fidx <= '0;
            st   <= S_FETCH;
          end
        end
        S_TAIL: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(HALF - 1)) begin
            cs_n <= 1'b1;
            done <= 1'b1;
            for (int i = 0; i < LANES; i++) tx_sh[i] <= '0;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R12
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (cs_n && !err));
  // R10
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdo));
  // R11
  cs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  // R11
  cs_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sclk);
  // R6
  mirror_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (mode_q != M_MIRROR));
  // R5
  mirror_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && mode_q == M_MIRROR) |-> (sdo == {LANES{sdo[0]}}));
  // R4
  single_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && mode_q == M_SINGLE) |-> ((sdo >> 1) == '0));
endmodule

// File: tb/mlspi_shift_bench.sv
module mlspi_shift_bench;
  localparam int LANES = 2;
  localparam int HALF  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] len_words = 8'd0;
  logic [7:0] tx_data, rx_data;
  logic tx_valid, tx_ready, rx_valid, busy, done, err, sclk, cs_n;
  logic [LANES-1:0] sdo, sdi;

  always #10 clk = ~clk;

  mlspi_shift #(.LANES(LANES), .WORD_W(8), .LEN_W(8), .HALF(HALF)) u_mlspi_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .len_words(len_words),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .done(done), .err(err),
    .sclk(sclk), .cs_n(cs_n), .sdo(sdo), .sdi(sdi));

  int total = 0;
  int bad = 0;

  logic [7:0] txq [8];
  int tbase = 0, tlen = 0, tcount = 0;
  assign tx_valid = (tcount - tbase) < tlen;
  assign tx_data  = txq[(tcount - tbase) & 7];
  always @(negedge clk) if (tx_valid && tx_ready) begin
    @(posedge clk);
    #1 tcount++;
  end

  logic [7:0] rxbuf [16];
  int rbase = 0, rcount = 0;
  always @(negedge clk) if (rx_valid) begin
    rxbuf[rcount & 15] = rx_data;
    rcount++;
  end

  logic [7:0] p_in  [LANES][8];
  logic [7:0] p_got [LANES][8];
  logic [7:0] p_sh  [LANES];
  int base = 0, nr = 0, nf = 0, cs_falls = 0;
  time t_csfall, t_first, t_lastfall, t_csrise;
  logic [31:0] pos_f;
  assign pos_f = nf - base;
  for (genvar g = 0; g < LANES; g++) begin : g_per
    assign sdi[g] = p_in[g][pos_f[5:3]][3'd7 - pos_f[2:0]];
  end
  always @(posedge sclk) if (!cs_n) begin
    if (nr == base) t_first = $time;
    for (int i = 0; i < LANES; i++) begin
      p_sh[i] = {p_sh[i][6:0], sdo[i]};
      if (((nr - base) & 7) == 7) p_got[i][((nr - base) >> 3) & 7] = p_sh[i];
    end
    nr++;
  end
  always @(negedge sclk) begin
    t_lastfall = $time;
    nf++;
  end
  always @(negedge cs_n) begin
    t_csfall = $time;
    cs_falls++;
  end
  always @(posedge cs_n) t_csrise = $time;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int done_cnt;
  bit err_seen, busy_seen;

  task automatic run(input logic [1:0] m, input int len);
    base = nr; tbase = tcount; rbase = rcount;
    tlen = len; done_cnt = 0;
    for (int i = 0; i < LANES; i++) for (int j = 0; j < 8; j++) p_got[i][j] = 8'h00;
    @(negedge clk);
    mode = m; len_words = 8'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    err_seen = err; busy_seen = busy;
    if (!err_seen) begin
      for (int k = 0; k < 4000 && done_cnt == 0; k++) begin
        @(negedge clk);
        if (done) begin
          done_cnt++;
          chk(!busy && cs_n, "R12 done with cs_n high and busy low", {busy, cs_n}, 2'b01);
        end
      end
      @(negedge clk);
      if (done) done_cnt++;
    end else begin
      @(negedge clk);
      chk(!err, "R2 err lasts one cycle", err, 0);
    end
    tlen = 0;
  endtask

  task automatic t_reset;
    chk(cs_n === 1'b1 && sclk === 1'b0, "R1 cs_n/sclk idle", {cs_n, sclk}, 2'b10);
    chk(sdo === '0 && busy === 1'b0 && tx_ready === 1'b0, "R1 sdo/busy/tx_ready", {sdo, busy, tx_ready}, 0);
    chk(rx_valid === 1'b0 && done === 1'b0 && err === 1'b0, "R1 rx_valid/done/err", {rx_valid, done, err}, 0);
  endtask

  task automatic t_single;
    txq[0] = 8'h88;
    p_in[0][0] = 8'h3C; p_in[1][0] = 8'hFF;
    run(2'd0, 1);
    chk(busy_seen, "R12 busy after accepted start", busy_seen, 1);
    chk(done_cnt == 1, "R12 single done pulse", done_cnt, 1);
    chk(p_got[0][0] == 8'h88, "R3 lane0 MSB-first out (R10)", p_got[0][0], 8'h88);
    chk(p_got[1][0] == 8'h00, "R4 unused lane held low", p_got[1][0], 0);
    chk(rcount - rbase == 1, "R3 one rx word", rcount - rbase, 1);
    chk(rxbuf[rbase & 15] == 8'h3C, "R3 rx from lane0 only (R4)", rxbuf[rbase & 15], 8'h3C);
    chk((t_first - t_csfall) == HALF * 20, "R11 cs lead", int'(t_first - t_csfall), HALF * 20);
    chk((t_csrise - t_lastfall) >= HALF * 20, "R11 cs lag", int'(t_csrise - t_lastfall), HALF * 20);
  endtask

  task automatic t_mirror;
    txq[0] = 8'h88; txq[1] = 8'h5B;
    p_in[0][0] = 8'h12; p_in[1][0] = 8'h34;
    run(2'd2, 2);
    chk(done_cnt == 1, "R12 mirror done pulse", done_cnt, 1);
    for (int i = 0; i < LANES; i++) begin
      chk(p_got[i][0] == 8'h88, "R5 mirror word0 on every lane", p_got[i][0], 8'h88);
      chk(p_got[i][1] == 8'h5B, "R5 mirror word1 on every lane", p_got[i][1], 8'h5B);
    end
    chk(rcount == rbase, "R6 mirror returns no rx", rcount - rbase, 0);
  endtask

  task automatic t_stripe2;
    txq[0] = 8'hA5; txq[1] = 8'h5A;
    p_in[0][0] = 8'h11; p_in[1][0] = 8'h88;
    run(2'd1, 2);
    chk(p_got[0][0] == 8'hA5, "R7 word0 on lane0", p_got[0][0], 8'hA5);
    chk(p_got[1][0] == 8'h5A, "R7 word1 on lane1", p_got[1][0], 8'h5A);
    chk(rcount - rbase == 2, "R8 two rx words", rcount - rbase, 2);
    chk(rxbuf[rbase & 15] == 8'h11, "R8 rx[0] from lane0", rxbuf[rbase & 15], 8'h11);
    chk(rxbuf[(rbase + 1) & 15] == 8'h88, "R8 rx[1] from lane1", rxbuf[(rbase + 1) & 15], 8'h88);
  endtask

  task automatic t_stripe4;
    txq[0] = 8'h01; txq[1] = 8'h02; txq[2] = 8'h03; txq[3] = 8'h04;
    p_in[0][0] = 8'hC0; p_in[1][0] = 8'hC1; p_in[0][1] = 8'hC2; p_in[1][1] = 8'hC3;
    run(2'd1, 4);
    chk(done_cnt == 1, "R12 stripe done pulse", done_cnt, 1);
    chk(p_got[0][1] == 8'h03, "R7 word2 on lane0", p_got[0][1], 8'h03);
    chk(p_got[1][1] == 8'h04, "R7 word3 on lane1", p_got[1][1], 8'h04);
    for (int k = 0; k < 4; k++)
      chk(rxbuf[(rbase + k) & 15] == 8'(8'hC0 + k), "R8 alternating rx order",
          rxbuf[(rbase + k) & 15], 8'hC0 + k);
  endtask

  task automatic t_reject(input logic [1:0] m, input int len, input string req);
    int f0;
    f0 = cs_falls;
    run(m, len);
    chk(err_seen, req, err_seen, 1);
    chk(!busy_seen, req, busy_seen, 0);
    repeat (10) @(negedge clk);
    chk(cs_falls == f0 && cs_n, req, cs_falls - f0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_mirror();
    t_stripe2();
    t_stripe4();
    t_reject(2'd3, 2, "R2 mode 3 rejected");
    t_reject(2'd1, 3, "R9 odd stripe length rejected");
    t_reject(2'd0, 0, "R9 zero length rejected");
    t_single();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule